// File: doc/BRIEF.md
# DMA Request Front End and Channel Arbiter

This block sits in front of the transfer engines of an eight-channel DMA controller. Each channel takes its request from one of three sources: a software auto-request that stays up while the channel is enabled, a request line from an on-chip peripheral, or an external request pin. External pins exist only for the lower four channels. Each pin passes through a two-flop synchronizer and then through a detector that can be set to low level, high level, rising edge or falling edge. An edge is remembered as pending until that channel is granted. A level is looked at afresh on every arbitration.

The arbiter gives one transfer slot at a time to one channel. The grant is one-hot, and it is held until the transfer engine reports the end of the slot. The arbiter can switch at run time between a fixed order and a rotating order. Per-channel acknowledge and transfer-end outputs carry active levels that are set independently. Transfer-end is shown while the engine flags the final unit of the granted channel.

Top module: `dma_req_front`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant_o` is zero and every `ack_o` and `tend_o` bit sits at its inactive level, which is the inverse of its polarity bit.
- R2: A channel requests only when its `ch_en_i` bit is 1. Its 2-bit source field `ch_src_i[2c+1:2c]` selects the request: 00 is an auto request, 01 follows `periph_req_i[c]`, 10 follows pin `c`, and 11 never requests.
- R3: Channels 4 to 7 with source code 10 never request and are never granted.
- R4: Pin `p` uses the code `pin_det_i[2p+1:2p]`: 00 is low level, 01 is high level, 10 is rising edge, 11 is falling edge. With the arbiter idle, a pin change driven between clock edges produces a grant on the third rising edge after it.
- R5: A detected edge stays pending until its channel is granted, including while another channel holds the grant. One edge yields exactly one grant.
- R6: A level request produces a new grant on every arbitration while the level is held. Once the level has been removed through the synchronizer, no further grant follows.
- R7: When `rr_mode_i` is 0, the lowest-numbered requesting channel wins.
- R8: When `rr_mode_i` is 1, the search starts at the channel after the last one granted and wraps around. After reset the last granted channel counts as channel 7.
- R9: `grant_o` is one-hot or zero. When idle, a grant loads on the edge after a request is seen. It stays unchanged until `slot_done_i` is sampled high, clears on that edge, and the next grant can load on the following edge.
- R10: `ack_o[c]` equals `ack_pol_i[c]` while channel `c` is granted and is inverted otherwise. A polarity bit of 1 means active high.
- R11: `tend_o[c]` equals `tend_pol_i[c]` while channel `c` is granted and `xfer_last_i` is 1. Otherwise it is the inverse.
- R12: An enabled auto-request channel is granted again after every slot for as long as it stays enabled and wins arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_req_i | input | 4 | External request pins, asynchronous |
| periph_req_i | input | 8 | Peripheral request line per channel |
| ch_en_i | input | 8 | Channel enable |
| ch_src_i | input | 16 | Request source code, 2 bits per channel |
| pin_det_i | input | 8 | Detection type, 2 bits per pin |
| rr_mode_i | input | 1 | 1 selects rotating order, 0 selects fixed order |
| slot_done_i | input | 1 | Transfer engine has finished the granted slot |
| xfer_last_i | input | 1 | The current unit is the final one of the granted channel |
| ack_pol_i | input | 8 | Active level of each acknowledge |
| tend_pol_i | input | 8 | Active level of each transfer-end |
| grant_o | output | 8 | One-hot channel grant |
| ack_o | output | 8 | Acknowledge per channel, polarity applied |
| tend_o | output | 8 | Transfer-end per channel, polarity applied |

## Verification
Auto and peripheral requests reach `grant_o` one rising edge after they are driven. Pin requests take three edges: two synchronizer stages and then the grant register. A grant clears one edge after `slot_done_i` and can reload one edge later. `ack_o` and `tend_o` follow the grant and `xfer_last_i` within the same cycle. Every input is driven on a falling edge and every output is sampled on a later falling edge, so the bench counts exact rising edges. For pins, it checks one edge before the due cycle that the grant is still absent, then checks that it appears in the due cycle.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    localparam int CH_COUNT  = 8;
    localparam int PIN_COUNT = 4;

    // Where a channel takes its request from
    typedef enum logic [1:0] {
        SRC_AUTO   = 2'b00,
        SRC_PERIPH = 2'b01,
        SRC_PIN    = 2'b10,
        SRC_NONE   = 2'b11
    } req_src_e;

    // How an external pin is interpreted
    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } pin_det_e;

    // Synchronizer taps of one pin: newest synchronized value and the one before
    typedef struct packed {
        logic meta;
        logic now;
        logic prev;
    } pin_sync_t;

    function automatic logic det_is_edge(pin_det_e d);
        return d == DET_RISE || d == DET_FALL;
    endfunction

    function automatic logic edge_seen(pin_det_e d, pin_sync_t s);
        return (d == DET_RISE) ? (s.now & ~s.prev) : (~s.now & s.prev);
    endfunction

endpackage

// File: rtl/dma_pin_detect.sv
module dma_pin_detect
    import dma_req_pkg::*;
#(
    parameter int PINS = PIN_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_i,
    input  logic [2*PINS-1:0] det_i,
    input  logic [PINS-1:0]   arm_i,
    input  logic [PINS-1:0]   clr_i,
    output logic [PINS-1:0]   req_o
);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pin_sync_t sync_q;
        logic      pend_q;
        logic      edge_now;
        pin_det_e  det;

        assign det      = pin_det_e'(det_i[2*p +: 2]);
        assign edge_now = det_is_edge(det) & edge_seen(det, sync_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                pend_q <= 1'b0;
            end else begin
                sync_q <= '{meta: pin_i[p], now: sync_q.meta, prev: sync_q.now};
                pend_q <= arm_i[p] & (pend_q | edge_now) & ~clr_i[p];
            end
        end

        always_comb begin
            unique case (det)
                DET_LOW:  req_o[p] = arm_i[p] & ~sync_q.now;
                DET_HIGH: req_o[p] = arm_i[p] &  sync_q.now;
                default:  req_o[p] = arm_i[p] & (pend_q | edge_now);
            endcase
        end

        // R5
        pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (pend_q && arm_i[p] && !clr_i[p]) |=> pend_q)
            else $error("pending edge lost on pin %0d", p);
    end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_req_pkg::*;
#(
    parameter int NCH = CH_COUNT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req_i,
    input  logic           rr_mode_i,
    input  logic           slot_done_i,
    output logic [NCH-1:0] grant_o,
    output logic [NCH-1:0] taken_o
);

    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] grant_q;
    logic [CW-1:0]  last_q;
    logic [NCH-1:0] win_oh;
    logic [CW-1:0]  win_idx;
    logic           load;

    always_comb begin
        int  start;
        int  idx;
        logic found;
        win_oh  = '0;
        win_idx = '0;
        found   = 1'b0;
        start   = rr_mode_i ? int'(last_q) + 1 : 0;
        if (start >= NCH) start = 0;
        for (int k = 0; k < NCH; k++) begin
            idx = start + k;
            if (idx >= NCH) idx = idx - NCH;
            if (!found && req_i[idx]) begin
                found       = 1'b1;
                win_oh[idx] = 1'b1;
                win_idx     = CW'(idx);
            end
        end
    end

    assign load    = (grant_q == '0) && (req_i != '0);
    assign taken_o = load ? win_oh : '0;
    assign grant_o = grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            last_q  <= CW'(NCH - 1);
        end else if (grant_q != '0 && slot_done_i) begin
            grant_q <= '0;
        end else if (load) begin
            grant_q <= win_oh;
            last_q  <= win_idx;
        end
    end

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q))
        else $error("grant not one-hot");

    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && !slot_done_i) |=> $stable(grant_q))
        else $error("grant changed inside a slot");

    // R9
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && slot_done_i) |=> (grant_q == '0))
        else $error("grant not released after slot end");

    // R9
    grant_to_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0 && req_i != '0) |=> ((grant_q & $past(req_i)) != '0))
        else $error("idle arbiter did not grant a requester");

endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
    import dma_req_pkg::*;
#(
    parameter int NCH  = CH_COUNT,
    parameter int NPIN = PIN_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPIN-1:0]   pin_req_i,
    input  logic [NCH-1:0]    periph_req_i,
    input  logic [NCH-1:0]    ch_en_i,
    input  logic [2*NCH-1:0]  ch_src_i,
    input  logic [2*NPIN-1:0] pin_det_i,
    input  logic              rr_mode_i,
    input  logic              slot_done_i,
    input  logic              xfer_last_i,
    input  logic [NCH-1:0]    ack_pol_i,
    input  logic [NCH-1:0]    tend_pol_i,
    output logic [NCH-1:0]    grant_o,
    output logic [NCH-1:0]    ack_o,
    output logic [NCH-1:0]    tend_o
);

    logic [NPIN-1:0] pin_arm;
    logic [NPIN-1:0] pin_req;
    logic [NCH-1:0]  chan_req;
    logic [NCH-1:0]  taken;
    logic [NCH-1:0]  grant;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        req_src_e src;
        logic     from_pin;
        assign src = req_src_e'(ch_src_i[2*c +: 2]);

        if (c < NPIN) begin : g_pinned
            assign pin_arm[c] = ch_en_i[c] && src == SRC_PIN;
            assign from_pin   = pin_req[c];
        end else begin : g_unpinned
            assign from_pin = 1'b0;
            // R3
            upper_pin_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(grant[c]) |-> ($past(ch_src_i[2*c +: 2]) != SRC_PIN))
                else $error("pin source granted on channel %0d", c);
        end

        always_comb begin
            unique case (src)
                SRC_AUTO:   chan_req[c] = ch_en_i[c];
                SRC_PERIPH: chan_req[c] = ch_en_i[c] & periph_req_i[c];
                SRC_PIN:    chan_req[c] = ch_en_i[c] & from_pin;
                default:    chan_req[c] = 1'b0;
            endcase
        end
    end

    dma_pin_detect #(.PINS(NPIN)) u_pins (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_req_i),
        .det_i (pin_det_i),
        .arm_i (pin_arm),
        .clr_i (taken[NPIN-1:0]),
        .req_o (pin_req)
    );

    dma_chan_arbiter #(.NCH(NCH)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .req_i       (chan_req),
        .rr_mode_i   (rr_mode_i),
        .slot_done_i (slot_done_i),
        .grant_o     (grant),
        .taken_o     (taken)
    );

    assign grant_o = grant;
    assign ack_o   = ~(ack_pol_i ^ grant);
    assign tend_o  = ~(tend_pol_i ^ (grant & {NCH{xfer_last_i}}));

endmodule

// File: tb/tb_dma_req_front.sv
`timescale 1ns/1ps
module tb_dma_req_front;

    localparam logic [7:0] ACKP  = 8'h0F;
    localparam logic [7:0] TENDP = 8'hAA;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  pin_req;
    logic [7:0]  periph_req;
    logic [7:0]  ch_en;
    logic [15:0] ch_src;
    logic [7:0]  pin_det;
    logic        rr_mode;
    logic        slot_done;
    logic        xfer_last;
    logic [7:0]  grant, ack, tend;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_req_front dut (
        .clk(clk), .rst(rst), .pin_req_i(pin_req), .periph_req_i(periph_req),
        .ch_en_i(ch_en), .ch_src_i(ch_src), .pin_det_i(pin_det),
        .rr_mode_i(rr_mode), .slot_done_i(slot_done), .xfer_last_i(xfer_last),
        .ack_pol_i(ACKP), .tend_pol_i(TENDP),
        .grant_o(grant), .ack_o(ack), .tend_o(tend)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_src(int ch, logic [1:0] code);
        ch_src[2*ch +: 2] = code;
    endtask

    task automatic set_det(int p, logic [1:0] code);
        pin_det[2*p +: 2] = code;
    endtask

    task automatic do_reset();
        rst = 1'b1; pin_req = 4'h0; periph_req = 8'h00; ch_en = 8'h00;
        ch_src = 16'hFFFF; pin_det = 8'h55; rr_mode = 1'b0;
        slot_done = 1'b0; xfer_last = 1'b0;
        cyc(2);
        rst = 1'b0;
    endtask

    // end the current slot, check the gap, then check the next grant
    task automatic serve(string req, logic [7:0] exp);
        slot_done = 1'b1;
        cyc(1);
        check("R9 release", grant, 8'h00);
        slot_done = 1'b0;
        cyc(1);
        check(req, grant, exp);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 grant", grant, 8'h00);
        check("R1 ack", ack, ~ACKP);
        check("R1 tend", tend, ~TENDP);
        cyc(1);
        check("R1 grant after release", grant, 8'h00);
    endtask

    task automatic t_fixed_auto();
        do_reset();
        set_src(2, 2'b00); set_src(5, 2'b00);
        ch_en[2] = 1'b1; ch_en[5] = 1'b1;
        cyc(1);
        check("R7 lowest wins", grant, 8'h04);
        check("R10 ack", ack, ~(ACKP ^ 8'h04));
        check("R11 tend idle", tend, ~TENDP);
        xfer_last = 1'b1; #1;
        check("R11 tend last", tend, ~(TENDP ^ 8'h04));
        xfer_last = 1'b0;
        cyc(3);
        check("R9 hold", grant, 8'h04);
        serve("R12 auto regrant", 8'h04);
        ch_en[2] = 1'b0;
        serve("R7 next channel", 8'h20);
        check("R10 ack ch5", ack, ~(ACKP ^ 8'h20));
    endtask

    task automatic t_round_robin();
        do_reset();
        rr_mode = 1'b1;
        set_src(1, 2'b00); set_src(3, 2'b00); set_src(6, 2'b00);
        ch_en = 8'h4A;
        cyc(1);
        check("R8 first after reset", grant, 8'h02);
        serve("R8 rotate to 3", 8'h08);
        serve("R8 rotate to 6", 8'h40);
        serve("R8 wrap to 1", 8'h02);
        rr_mode = 1'b0;
        serve("R7 fixed again", 8'h02);
    endtask

    task automatic t_sources();
        do_reset();
        set_src(4, 2'b01); ch_en[4] = 1'b1;
        set_src(0, 2'b11); ch_en[0] = 1'b1;
        set_src(6, 2'b00);
        cyc(4);
        check("R2 no periph, none code, disabled", grant, 8'h00);
        periph_req[4] = 1'b1;
        cyc(1);
        check("R2 periph grant", grant, 8'h10);
        periph_req[4] = 1'b0;
        serve("R2 periph dropped", 8'h00);
        cyc(3);
        check("R2 still idle", grant, 8'h00);
    endtask

    task automatic t_upper_pin();
        do_reset();
        pin_req = 4'hF;
        set_src(5, 2'b10); ch_en[5] = 1'b1;
        set_src(7, 2'b10); ch_en[7] = 1'b1;
        cyc(6);
        check("R3 upper pin ignored", grant, 8'h00);
    endtask

    task automatic t_level();
        do_reset();
        set_det(0, 2'b01); set_det(1, 2'b00);
        pin_req[1] = 1'b1;
        set_src(0, 2'b10); ch_en[0] = 1'b1;
        cyc(4);
        check("R4 high level idle", grant, 8'h00);
        pin_req[0] = 1'b1;
        cyc(2);
        check("R4 not before third edge", grant, 8'h00);
        cyc(1);
        check("R4 high level grant", grant, 8'h01);
        serve("R6 level held regrant", 8'h01);
        pin_req[0] = 1'b0;
        cyc(3);
        serve("R6 level removed", 8'h00);
        cyc(3);
        check("R6 no more grants", grant, 8'h00);
        set_src(1, 2'b10); ch_en[1] = 1'b1;
        cyc(3);
        check("R4 low level pin high", grant, 8'h00);
        pin_req[1] = 1'b0;
        cyc(2);
        check("R4 low not yet", grant, 8'h00);
        cyc(1);
        check("R4 low level grant", grant, 8'h02);
    endtask

    task automatic t_edge();
        do_reset();
        set_det(2, 2'b10); set_det(3, 2'b11);
        pin_req[3] = 1'b1;
        set_src(0, 2'b00); ch_en[0] = 1'b1;
        cyc(3);
        set_src(2, 2'b10); ch_en[2] = 1'b1;
        set_src(3, 2'b10); ch_en[3] = 1'b1;
        check("R5 ch0 holds", grant, 8'h01);
        pin_req[2] = 1'b1;
        pin_req[3] = 1'b0;
        cyc(1);
        pin_req[2] = 1'b0;
        cyc(4);
        check("R5 busy keeps grant", grant, 8'h01);
        ch_en[0] = 1'b0;
        serve("R5 rise pending served", 8'h04);
        serve("R5 fall pending served", 8'h08);
        serve("R5 single grant per edge", 8'h00);
        cyc(3);
        check("R5 no repeat", grant, 8'h00);
        pin_req[2] = 1'b1;
        cyc(2);
        check("R4 edge not yet", grant, 8'h00);
        cyc(1);
        check("R4 rise latency", grant, 8'h04);
        serve("R5 held pin no regrant", 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fixed_auto();
        t_round_robin();
        t_sources();
        t_upper_pin();
        t_level();
        t_edge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule